// File: doc/BRIEF.md
# Multi-Mode Effective Address Sequencer

This block works out where an instruction's memory operand lives and fetches it. A request carries an addressing-mode code, a base register value, an index register value, a literal field (used as immediate, displacement or absolute address depending on the mode) and a scale code. The sequencer computes the effective address, drives a single memory read port and returns the operand value. Pointer-update modes also return a write-back value for the base register.

The sequencer accepts one request at a time through a valid/ready handshake. Modes that need no memory finish one cycle after acceptance. Modes with one read take three cycles, and the memory-indirect mode takes five because it reads twice. The memory port has a fixed latency of one cycle: data appears in the cycle after the read strobe. The result is presented for exactly one cycle with `done`.

Top module: `ea_sequencer`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), req_ready is 1 and done, mem_rd_en and wb_en are 0.
- R2: Mode 0 (register) returns req_base and mode 1 (immediate) returns req_imm as the operand, with no memory read.
- R3: Mode 2 (displacement) returns the memory word at req_imm + req_base.
- R4: Mode 3 (register indirect) returns the memory word at req_base, and mode 5 (absolute) returns the memory word at req_imm.
- R5: Mode 4 (indexed) returns the memory word at req_base + req_index.
- R6: Mode 9 (scaled) returns the memory word at req_imm + req_base + req_index*d, where scale code s (0..3) gives d = 2^s.
- R7: Mode 6 (memory indirect) reads at req_base, then returns the memory word at the address that the first read produced, using exactly two reads.
- R8: Mode 7 (post-increment) returns the memory word at req_base and asserts wb_en with wb_value = req_base + d. No other mode except mode 8 asserts wb_en.
- R9: Mode 8 (pre-decrement) returns the memory word at req_base - d and asserts wb_en with wb_value = req_base - d.
- R10: All address and write-back arithmetic wraps modulo 2^DW.
- R11: done is a one-cycle pulse. It rises 1, 3 or 5 clock edges after the accepting edge (counting that edge) for zero, one or two reads respectively.
- R12: req_ready is 0 from the accepting edge until done has been shown. A request offered while busy is ignored and produces no further done.
- R13: Mode codes 10 to 15 return operand 0, read no memory, assert no write-back and finish like a register-mode request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_mode | input | 4 | Addressing-mode code |
| req_base | input | DW | Base register value |
| req_index | input | DW | Index register value |
| req_imm | input | DW | Literal, displacement or absolute address |
| req_scale | input | SCW | Scale code s, d = 2^s |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | DW | Memory read address |
| mem_rdata | input | DW | Read data, valid the cycle after mem_rd_en |
| done | output | 1 | Result valid for this cycle |
| operand | output | DW | Operand value |
| wb_en | output | 1 | Base-register write-back request |
| wb_value | output | DW | Updated base-register value |

## Verification
The bench uses the default DW = 32 and SCW = 2. With 32-bit words, sums that run past 2^32 and a decrement below zero fall within a few directed vectors. A two-bit scale code covers all four scale factors, 1, 2, 4 and 8. The memory model returns a scrambled function of the address, so a wrong address or a skipped indirection shows up in the operand.

// File: rtl/ea_pkg.sv
// Shared types for the effective-address sequencer.
// Assumes a 4-bit mode code; codes above MODE_SCALED are unsupported.
package ea_pkg;

    typedef enum logic [3:0] {
        MODE_REG     = 4'd0,
        MODE_IMM     = 4'd1,
        MODE_DISP    = 4'd2,
        MODE_RIND    = 4'd3,
        MODE_INDEXED = 4'd4,
        MODE_ABS     = 4'd5,
        MODE_MEMIND  = 4'd6,
        MODE_POSTINC = 4'd7,
        MODE_PREDEC  = 4'd8,
        MODE_SCALED  = 4'd9
    } ea_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DATA,
        ST_FIN
    } seq_state_e;

endpackage

// File: rtl/ea_addr_gen.sv
// Address generator: combinational decode of one request into the first
// read address, the number of reads, a literal result for modes without
// memory, and the base write-back value.
// Assumes the scale code selects d = 2^scale; all sums wrap modulo 2^DW.
module ea_addr_gen
    import ea_pkg::*;
#(
    parameter int DW  = 32,
    parameter int SCW = 2
) (
    input  ea_mode_e          mode,
    input  logic [DW-1:0]     base,
    input  logic [DW-1:0]     index,
    input  logic [DW-1:0]     imm,
    input  logic [SCW-1:0]    scale,
    output logic [DW-1:0]     addr,
    output logic [1:0]        reads,
    output logic [DW-1:0]     lit,
    output logic              wb_req,
    output logic [DW-1:0]     wb_val
);

    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    logic [DW-1:0] step;
    logic [DW-1:0] scaled_idx;

    // Operand size and scaled index, both as left shifts.
    always_comb begin
        step       = ONE << scale;
        scaled_idx = index << scale;
    end

    // Per-mode address, read count, literal and write-back.
    always_comb begin
        addr   = '0;
        reads  = 2'd0;
        lit    = '0;
        wb_req = 1'b0;
        wb_val = '0;
        case (mode)
            MODE_REG:     lit = base;
            MODE_IMM:     lit = imm;
            MODE_DISP:    begin addr = imm + base;  reads = 2'd1; end
            MODE_RIND:    begin addr = base;        reads = 2'd1; end
            MODE_INDEXED: begin addr = base + index; reads = 2'd1; end
            MODE_ABS:     begin addr = imm;         reads = 2'd1; end
            MODE_MEMIND:  begin addr = base;        reads = 2'd2; end
            MODE_POSTINC: begin
                addr   = base;
                reads  = 2'd1;
                wb_req = 1'b1;
                wb_val = base + step;
            end
            MODE_PREDEC: begin
                addr   = base - step;
                reads  = 2'd1;
                wb_req = 1'b1;
                wb_val = base - step;
            end
            MODE_SCALED:  begin addr = imm + base + scaled_idx; reads = 2'd1; end
            default:      lit = '0;
        endcase
    end

endmodule

// File: rtl/ea_ctrl.sv
// Sequencer control: accepts a decoded request, issues up to two memory
// reads (one-cycle latency), chains the indirect read, and presents the
// result for one cycle.
// Assumes mem_rdata is valid exactly one cycle after a read strobe.
module ea_ctrl
    import ea_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [DW-1:0]  dec_addr,
    input  logic [1:0]     dec_reads,
    input  logic [DW-1:0]  dec_lit,
    input  logic           dec_wb_req,
    input  logic [DW-1:0]  dec_wb_val,
    output logic           mem_rd_en,
    output logic [DW-1:0]  mem_addr,
    input  logic [DW-1:0]  mem_rdata,
    output logic           done,
    output logic [DW-1:0]  operand,
    output logic           wb_en,
    output logic [DW-1:0]  wb_value
);

    seq_state_e     state_q;
    logic [DW-1:0]  addr_q;
    logic [1:0]     pass_q;
    logic [DW-1:0]  opnd_q;
    logic           wb_en_q;
    logic [DW-1:0]  wb_val_q;

    // State machine and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            pass_q   <= 2'd0;
            opnd_q   <= '0;
            wb_en_q  <= 1'b0;
            wb_val_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    addr_q   <= dec_addr;
                    pass_q   <= dec_reads;
                    opnd_q   <= dec_lit;
                    wb_en_q  <= dec_wb_req;
                    wb_val_q <= dec_wb_val;
                    state_q  <= (dec_reads == 2'd0) ? ST_FIN : ST_ISSUE;
                end
                ST_ISSUE: state_q <= ST_DATA;
                ST_DATA: begin
                    if (pass_q == 2'd2) begin
                        addr_q  <= mem_rdata;
                        pass_q  <= 2'd1;
                        state_q <= ST_ISSUE;
                    end else begin
                        opnd_q  <= mem_rdata;
                        state_q <= ST_FIN;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mem_rd_en = (state_q == ST_ISSUE);
        mem_addr  = addr_q;
        done      = (state_q == ST_FIN);
        operand   = opnd_q;
        wb_en     = done && wb_en_q;
        wb_value  = wb_val_q;
    end

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_after_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_no_ready_on_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);

    assert_read_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (!mem_rd_en && !done && !req_ready));

    assert_wb_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

endmodule

// File: rtl/ea_sequencer.sv
// Top of the effective-address sequencer: decodes the addressing mode,
// runs the read sequence and returns operand plus optional write-back.
// Assumes a memory port with fixed one-cycle read latency.
module ea_sequencer
    import ea_pkg::*;
#(
    parameter int DW  = 32,
    parameter int SCW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [3:0]      req_mode,
    input  logic [DW-1:0]   req_base,
    input  logic [DW-1:0]   req_index,
    input  logic [DW-1:0]   req_imm,
    input  logic [SCW-1:0]  req_scale,
    output logic            mem_rd_en,
    output logic [DW-1:0]   mem_addr,
    input  logic [DW-1:0]   mem_rdata,
    output logic            done,
    output logic [DW-1:0]   operand,
    output logic            wb_en,
    output logic [DW-1:0]   wb_value
);

    logic [DW-1:0] dec_addr;
    logic [1:0]    dec_reads;
    logic [DW-1:0] dec_lit;
    logic          dec_wb_req;
    logic [DW-1:0] dec_wb_val;

    ea_addr_gen #(.DW(DW), .SCW(SCW)) u_gen (
        .mode   (ea_mode_e'(req_mode)),
        .base   (req_base),
        .index  (req_index),
        .imm    (req_imm),
        .scale  (req_scale),
        .addr   (dec_addr),
        .reads  (dec_reads),
        .lit    (dec_lit),
        .wb_req (dec_wb_req),
        .wb_val (dec_wb_val)
    );

    ea_ctrl #(.DW(DW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .dec_addr   (dec_addr),
        .dec_reads  (dec_reads),
        .dec_lit    (dec_lit),
        .dec_wb_req (dec_wb_req),
        .dec_wb_val (dec_wb_val),
        .mem_rd_en  (mem_rd_en),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .done       (done),
        .operand    (operand),
        .wb_en      (wb_en),
        .wb_value   (wb_value)
    );

endmodule

// File: tb/sim_ea_sequencer.sv
`timescale 1ns/1ps
module sim_ea_sequencer;

    typedef struct packed {
        logic [3:0]  mode;
        logic [31:0] base;
        logic [31:0] index;
        logic [31:0] imm;
        logic [1:0]  scale;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{4'd0,  32'h1234_5678, 32'h0,         32'h9999_0000, 2'd0},
        '{4'd1,  32'h1111_1111, 32'h0,         32'hDEAD_BEEF, 2'd0},
        '{4'd2,  32'h0000_1000, 32'h0,         32'h0000_0020, 2'd0},
        '{4'd3,  32'h0000_4000, 32'h0,         32'h0000_0000, 2'd0},
        '{4'd5,  32'h0000_0077, 32'h0,         32'h8000_0010, 2'd0},
        '{4'd4,  32'h0000_0100, 32'h0000_0023, 32'h0,         2'd0},
        '{4'd9,  32'h0000_0100, 32'h0000_0003, 32'h0000_0010, 2'd2},
        '{4'd9,  32'h0000_0000, 32'hFFFF_FFFF, 32'h0,         2'd3},
        '{4'd6,  32'h0000_2000, 32'h0,         32'h0,         2'd0},
        '{4'd7,  32'h0000_3000, 32'h0,         32'h0,         2'd2},
        '{4'd8,  32'h0000_3000, 32'h0,         32'h0,         2'd3},
        '{4'd12, 32'hCAFE_0000, 32'h5,         32'h7,         2'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_mode = '0;
    logic [31:0] req_base = '0;
    logic [31:0] req_index = '0;
    logic [31:0] req_imm = '0;
    logic [1:0]  req_scale = '0;
    logic        mem_rd_en;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [31:0] operand;
    logic        wb_en;
    logic [31:0] wb_value;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ea_sequencer #(.DW(32), .SCW(2)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_base(req_base), .req_index(req_index),
        .req_imm(req_imm), .req_scale(req_scale), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done),
        .operand(operand), .wb_en(wb_en), .wb_value(wb_value)
    );

    function automatic logic [31:0] memf(logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A5A_C3C3;
    endfunction

    // Memory model with one-cycle read latency.
    always @(posedge clk) if (mem_rd_en) mem_rdata <= memf(mem_addr);

    function automatic string tag_of(logic [3:0] m);
        case (m)
            4'd0, 4'd1: return "R2";
            4'd2:       return "R3";
            4'd3, 4'd5: return "R4";
            4'd4:       return "R5";
            4'd6:       return "R7";
            4'd7:       return "R8";
            4'd8:       return "R9";
            4'd9:       return "R6";
            default:    return "R13";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference model derived from the requirements.
    task automatic model(vec_t v, output logic [31:0] op, output logic we,
                         output logic [31:0] wv, output int rd);
        logic [31:0] d;
        d  = 32'd1 << v.scale;
        op = 32'h0; we = 1'b0; wv = 32'h0; rd = 0;
        case (v.mode)
            4'd0: op = v.base;
            4'd1: op = v.imm;
            4'd2: begin op = memf(v.imm + v.base); rd = 1; end
            4'd3: begin op = memf(v.base); rd = 1; end
            4'd4: begin op = memf(v.base + v.index); rd = 1; end
            4'd5: begin op = memf(v.imm); rd = 1; end
            4'd6: begin op = memf(memf(v.base)); rd = 2; end
            4'd7: begin op = memf(v.base); rd = 1; we = 1'b1; wv = v.base + d; end
            4'd8: begin op = memf(v.base - d); rd = 1; we = 1'b1; wv = v.base - d; end
            4'd9: begin op = memf(v.imm + v.base + v.index * d); rd = 1; end
            default: ;
        endcase
    endtask

    // Drive one request and collect the result, edges to done and reads.
    task automatic run(vec_t v, output logic [31:0] op, output logic we,
                       output logic [31:0] wv, output int edges, output int rds);
        @(negedge clk);
        req_mode = v.mode; req_base = v.base; req_index = v.index;
        req_imm = v.imm; req_scale = v.scale; req_valid = 1'b1;
        edges = 0; rds = 0; op = '0; we = 1'b0; wv = '0;
        while (edges < 20) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (edges == 1) req_valid = 1'b0;
            if (mem_rd_en) rds++;
            if (done) begin
                op = operand; we = wb_en; wv = wb_value;
                break;
            end
        end
    endtask

    task automatic check_vec(vec_t v, string tag);
        logic [31:0] eop, eop2, ewv, aop, awv;
        logic ewe, awe;
        int erd, edg, ard;
        model(v, eop, ewe, ewv, erd);
        run(v, aop, awe, awv, edg, ard);
        chk({tag, " operand"}, aop, eop);
        chk({tag, " read count"}, 32'(ard), 32'(erd));
        chk("R11 edges to done", 32'(edg), 32'(1 + 2 * erd));
        chk({tag, " wb_en (R8)"}, {31'd0, awe}, {31'd0, ewe});
        if (ewe) chk({tag, " wb_value"}, awv, ewv);
        eop2 = eop;
    endtask

    initial begin
        #(200000 * 10);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 mem_rd_en", {31'd0, mem_rd_en}, 32'd0);
        chk("R1 wb_en", {31'd0, wb_en}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) check_vec(VEC[i], tag_of(VEC[i].mode));

        // R10: wrap of displacement sum and of pre-decrement below zero
        check_vec('{4'd2, 32'hFFFF_FFF0, 32'h0, 32'h0000_0020, 2'd0}, "R10");
        check_vec('{4'd8, 32'h0000_0000, 32'h0, 32'h0, 2'd0}, "R10");
        check_vec('{4'd15, 32'h1, 32'h2, 32'h3, 2'd3}, "R13");

        // R12: request offered while busy is ignored
        begin
            logic [31:0] eop, ewv;
            logic ewe;
            int erd, n, dones;
            vec_t v;
            v = '{4'd6, 32'h0000_5000, 32'h0, 32'h0, 2'd0};
            model(v, eop, ewe, ewv, erd);
            @(negedge clk);
            req_mode = v.mode; req_base = v.base; req_valid = 1'b1;
            @(posedge clk);
            @(negedge clk);
            req_mode = 4'd1; req_imm = 32'h0BAD_0BAD;
            n = 0;
            while (!done && n < 20) begin
                chk("R12 ready low while busy", {31'd0, req_ready}, 32'd0);
                @(posedge clk);
                @(negedge clk);
                n++;
            end
            chk("R12 operand of first request", operand, eop);
            req_valid = 1'b0;
            dones = 0;
            repeat (4) begin
                @(posedge clk);
                @(negedge clk);
                if (done) dones++;
            end
            chk("R12 no extra done", 32'(dones), 32'd0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule